// File: doc/BRIEF.md
# Multi-sample converter acquisition sequencer

This block is the host side of a bus-attached analog-to-digital converter that uses a strobe handshake: chip select, a write strobe that starts a conversion, an active-low completion line, and a read strobe that puts the result on the data bus. A single `start` pulse makes the sequencer take a fixed number of samples. For each sample it starts a conversion, waits for completion, reads the byte and writes it into a result memory through a simple write port. Consecutive samples go to consecutive addresses from a base. When the last byte is stored, a one-cycle `done` pulse marks the end of the run.

Completion can be detected in two ways, and `poll_mode` picks one at the start of each run. In polling mode the sequencer watches the completion line. It keeps a set minimum gap between that line falling and the read strobe. A watchdog ends the run with an error if completion never arrives. In timeout mode it ignores the completion line and waits a fixed number of cycles after each start. Every delay is a parameter counted in system clock cycles.

Top module: `adc_acq_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `cs_n`, `wr_n` and `rd_n` are high and `busy`, `done`, `st_we` and `wdog_err` are low.
- R2: A `start` pulse while idle raises `busy`. Each conversion then begins with `wr_n` low for exactly `WR_CYC` cycles, with `cs_n` low for the whole strobe.
- R3: In polling mode (`poll_mode`=1 at start), `rd_n` falls only after `intr_n` has fallen following the latest write strobe, and at least `RD_GAP` cycles after that fall.
- R4: In timeout mode (`poll_mode`=0 at start), `rd_n` falls exactly `WAIT_CYC` cycles after `wr_n` rises, whatever `intr_n` does, including when it never falls.
- R5: The read strobe lasts exactly `RD_CYC` cycles. The byte on `conv_data` in its last cycle is the byte that is stored.
- R6: `cs_n` goes high after every read and is high in the cycle before every write strobe begins.
- R7: Sample k (k = 0 .. `NSAMP`-1) is stored with a one-cycle `st_we`, at `st_addr` = `BASE` + k, in that order, with `st_data` equal to the converter's k-th result.
- R8: After the `NSAMP`-th store, `done` is high for exactly one cycle with `busy` low. A run produces exactly `NSAMP` stores (default 8).
- R9: In polling mode, if `intr_n` stays high for `WDOG` cycles after a write strobe, `wdog_err` goes high and the run stops with no further store and no `done`. `cs_n` goes high and `busy` low. `wdog_err` stays set until the next `start`, which clears it.
- R10: A `start` pulse while `busy` is high is ignored. The run goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| poll_mode | input | 1 | 1 = wait on completion line, 0 = fixed wait; taken at start |
| cs_n | output | 1 | Converter chip select, active low |
| wr_n | output | 1 | Conversion start strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| intr_n | input | 1 | Converter completion line, active low |
| conv_data | input | DW | Converter data bus |
| st_we | output | 1 | Result memory write enable |
| st_addr | output | AW | Result memory address |
| st_data | output | DW | Result memory write data |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the final store |
| wdog_err | output | 1 | Completion watchdog expired in the last run |

## Verification
The bench runs a converter model with a completion latency chosen per run. One run has a latency of a single cycle, so the completion line falls almost as soon as the write strobe ends. A design that did not hold the read gap would strobe the read too early. A timeout run in which the model never signals completion catches a design that still listens to the completion line in that mode: it would hang, or read at the wrong time. A second start pulse in the middle of a run would reset the address or add stores if it were not ignored. A polling run with a converter that never responds checks that the watchdog aborts the run cleanly and that the error flag survives until the next start clears it.

// File: rtl/adc_acq_seq.sv
module adc_acq_seq #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int BASE     = 60,
  parameter int NSAMP    = 8,
  parameter int WR_CYC   = 19,
  parameter int WAIT_CYC = 7500,
  parameter int RD_GAP   = 75,
  parameter int RD_CYC   = 4,
  parameter int WDOG     = 12500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          poll_mode,
  output logic          cs_n,
  output logic          wr_n,
  output logic          rd_n,
  input  logic          intr_n,
  input  logic [DW-1:0] conv_data,
  output logic          st_we,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          busy,
  output logic          done,
  output logic          wdog_err
);

  localparam int M0   = (WAIT_CYC > WDOG) ? WAIT_CYC : WDOG;
  localparam int M1   = (M0 > RD_GAP) ? M0 : RD_GAP;
  localparam int M2   = (M1 > WR_CYC) ? M1 : WR_CYC;
  localparam int MAXC = (M2 > RD_CYC) ? M2 : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int IW   = (NSAMP > 1) ? $clog2(NSAMP) : 1;

  localparam logic [CW-1:0] WR_L   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] WAIT_L = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] GAP_L  = CW'(RD_GAP - 1);
  localparam logic [CW-1:0] RD_L   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WDOG_L = CW'(WDOG - 1);
  localparam logic [IW-1:0] LAST   = IW'(NSAMP - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_WAIT, S_GAP, S_RD, S_STORE, S_DONE
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          mode_q;
  logic          err;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      mode_q <= 1'b0;
      err    <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_WR;
          cnt    <= '0;
          idx    <= '0;
          mode_q <= poll_mode;
          err    <= 1'b0;
        end
        S_WR: if (cnt == WR_L) begin
          state <= S_WAIT;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_WAIT: begin
          if (mode_q) begin
            if (!intr_n) begin
              state <= S_GAP;
              cnt   <= '0;
            end else if (cnt == WDOG_L) begin
              state <= S_IDLE;
              err   <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end else if (cnt == WAIT_L) begin
            state <= S_RD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: if (cnt == GAP_L) begin
          state <= S_RD;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        S_RD: if (cnt == RD_L) begin
          state  <= S_STORE;
          data_q <= conv_data;
        end else cnt <= cnt + 1'b1;
        S_STORE: if (idx == LAST) state <= S_DONE;
        else begin
          idx   <= idx + 1'b1;
          cnt   <= '0;
          state <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cs_n     = !(state inside {S_WR, S_WAIT, S_GAP, S_RD});
  assign wr_n     = (state != S_WR);
  assign rd_n     = (state != S_RD);
  assign st_we    = (state == S_STORE);
  assign st_addr  = AW'(BASE) + AW'(idx);
  assign st_data  = data_q;
  assign busy     = (state != S_IDLE) && (state != S_DONE);
  assign done     = (state == S_DONE);
  assign wdog_err = err;

  p_strobes_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
  p_strobe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
  p_store_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> ((st_addr - AW'(BASE)) < AW'(NSAMP)));
  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_err) |-> (!busy && cs_n && !done));
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/sim_adc_acq_seq.sv
module sim_adc_acq_seq;
  localparam int DW = 8, AW = 8, BASE = 8'h3C, NSAMP = 8;
  localparam int WR_CYC = 3, WAIT_CYC = 40, RD_GAP = 5, RD_CYC = 2, WDOG = 60;

  logic clk = 0, rst_n = 0, start = 0, poll_mode = 0;
  logic cs_n, wr_n, rd_n, st_we, busy, done, wdog_err;
  logic intr_n = 1'b1;
  logic [DW-1:0] conv_data, st_data;
  logic [AW-1:0] st_addr;

  always #4 clk = ~clk;

  adc_acq_seq #(.DW(DW), .AW(AW), .BASE(BASE), .NSAMP(NSAMP), .WR_CYC(WR_CYC),
    .WAIT_CYC(WAIT_CYC), .RD_GAP(RD_GAP), .RD_CYC(RD_CYC), .WDOG(WDOG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_mode(poll_mode),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .intr_n(intr_n), .conv_data(conv_data),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .busy(busy), .done(done), .wdog_err(wdog_err));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  logic [7:0] m_seed = 0, m_lat = 1, m_res = 0, lc = 0;
  logic m_mute = 0, pend = 0, mw_prev = 1;
  int mk = 0;
  assign conv_data = m_res;
  always @(negedge clk) begin
    mw_prev <= wr_n;
    if (start && !busy) mk <= 0;
    if (!cs_n && !wr_n) begin intr_n <= 1'b1; pend <= 1'b0; end
    if (!mw_prev && wr_n && !cs_n) begin
      m_res <= 8'(m_seed + mk * 29);
      mk    <= mk + 1;
      pend  <= 1'b1;
      lc    <= 0;
    end else if (pend) begin
      lc <= lc + 1;
      if (lc == m_lat - 1) begin
        pend <= 1'b0;
        if (!m_mute) intr_n <= 1'b0;
      end
    end
    if (!rd_n && !cs_n) intr_n <= 1'b1;
  end

  // monitor
  int cyc = 0, t_wrf = 0, t_wrr = 0, t_intf = -1000, t_rdf = 0;
  int nst = 0, ndone = 0, busy_at_done = 0;
  logic [AW-1:0] sa [16];
  logic [DW-1:0] sd [16];
  logic p_wr = 1, p_rd = 1, p_int = 1, p_cs = 1;
  always @(negedge clk) begin
    cyc++;
    if (start && !busy) begin nst = 0; ndone = 0; end
    if (p_wr && !wr_n) begin
      t_wrf = cyc;
      chk(!cs_n, "R2 cs low at write", cs_n, 0);
      chk(p_cs, "R6 cs high before write", p_cs, 1);
    end
    if (!p_wr && wr_n) begin
      t_wrr = cyc;
      chk(cyc - t_wrf == WR_CYC, "R2 write width", cyc - t_wrf, WR_CYC);
    end
    if (p_int && !intr_n) t_intf = cyc;
    if (p_rd && !rd_n) begin
      t_rdf = cyc;
      if (poll_mode) begin
        chk(t_intf > t_wrr, "R3 read after completion", t_intf, t_wrr);
        chk(cyc - t_intf >= RD_GAP, "R3 read gap", cyc - t_intf, RD_GAP);
      end else
        chk(cyc - t_wrr == WAIT_CYC, "R4 fixed wait", cyc - t_wrr, WAIT_CYC);
    end
    if (!p_rd && rd_n)
      chk(cyc - t_rdf == RD_CYC, "R5 read width", cyc - t_rdf, RD_CYC);
    if (st_we) begin
      if (nst < 16) begin sa[nst] = st_addr; sd[nst] = st_data; end
      nst++;
    end
    if (done) begin ndone++; busy_at_done = busy; end
    p_wr = wr_n; p_rd = rd_n; p_int = intr_n; p_cs = cs_n;
  end

  // run table: {poll, lat, seed, mute}
  localparam logic [17:0] VEC [4] = '{
    {1'b1, 8'd10, 8'h11, 1'b0},
    {1'b1, 8'd1,  8'hA5, 1'b0},
    {1'b0, 8'd20, 8'h00, 1'b1},
    {1'b0, 8'd30, 8'hF0, 1'b0}
  };

  task automatic pulse_start(input bit pm);
    poll_mode = pm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    for (int n = 0; n < lim && (busy || start); n++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  int wd = 0;
  initial begin
    while (wd < 150000) begin @(posedge clk); wd++; end
    chk(0, "watchdog", wd, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !busy && !done && !st_we && !wdog_err,
        "R1 reset state", {cs_n, wr_n, rd_n, busy, done, st_we, wdog_err}, 7'b1110000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rd_n && !busy && !done && !st_we,
        "R1 idle after reset", {cs_n, wr_n, rd_n, busy, done, st_we}, 6'b111000);

    for (int i = 0; i < 4; i++) begin
      m_lat = VEC[i][16:9]; m_seed = VEC[i][8:1]; m_mute = VEC[i][0];
      pulse_start(VEC[i][17]);
      chk(busy, "R2 busy after start", busy, 1);
      if (i == 0) begin
        repeat (50) @(negedge clk);
        pulse_start(1'b1);
        chk(busy, "R10 still busy after second start", busy, 1);
      end
      wait_idle(3000);
      chk(nst == NSAMP, "R8 store count", nst, NSAMP);
      chk(ndone == 1, "R8 one done pulse", ndone, 1);
      chk(busy_at_done == 0, "R8 busy low at done", busy_at_done, 0);
      for (int k = 0; k < NSAMP && k < nst; k++) begin
        chk(sa[k] == AW'(BASE + k), "R7 address", sa[k], BASE + k);
        chk(sd[k] == 8'(VEC[i][8:1] + k * 29), "R7 R5 data", sd[k], 8'(VEC[i][8:1] + k * 29));
      end
      chk(!wdog_err, "R9 no error on good run", wdog_err, 0);
    end

    // watchdog: polling with a silent converter
    m_lat = 8'd5; m_seed = 8'h42; m_mute = 1'b1;
    pulse_start(1'b1);
    repeat (WR_CYC + WDOG + 20) @(negedge clk);
    chk(wdog_err, "R9 watchdog flag", wdog_err, 1);
    chk(!busy && cs_n, "R9 run aborted", {busy, cs_n}, 2'b01);
    chk(nst == 0 && ndone == 0, "R9 no store or done", nst + ndone, 0);
    repeat (20) @(negedge clk);
    chk(wdog_err, "R9 flag held", wdog_err, 1);
    m_mute = 1'b0;
    pulse_start(1'b1);
    chk(!wdog_err, "R9 cleared by start", wdog_err, 0);
    wait_idle(3000);
    chk(nst == NSAMP && ndone == 1, "R8 run after error", nst, NSAMP);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule